// File: doc/BRIEF.md
# Prioritised Restart Interrupt Controller

This block arbitrates the interrupt sources of a small processor core. Five request lines compete. A non-maskable trap line is the strongest. Three maskable restart lines (high, middle and low) each have their own mask bit. A general request line is the weakest; for it the external system must place the instruction on the bus. The block holds a global interrupt-enable bit and the three mask bits. The core raises a sample strobe in the next-to-last clock of each instruction. Only in that clock does the block select the strongest eligible request.

On the clock edge that ends a sample cycle, the block registers its decision. A restart source produces a vector address. The general request produces an acknowledge strobe and a program-counter hold. Every acceptance clears the global enable. Pushing the program counter and fetching from the vector are left to the core.

Top module: `restart_intc`

## Requirements
- R1: When several sources are eligible in a sample cycle, exactly one is accepted, in the order trap (src bit 4), high (bit 3), middle (bit 2), low (bit 1), general (bit 0). `src_o` is one-hot on that encoding.
- R2: A request is taken only at a clock edge where `sample_i` is high. `take_o` and the other result outputs are valid for exactly the one cycle that follows that edge, and they are all zero at any other time.
- R3: The trap is accepted regardless of the global enable and of every mask bit.
- R4: A restart line is taken only while the global enable is set and its mask bit is 0. The mask bits are: bit 2 high, bit 1 middle, bit 0 low. Reset sets all three mask bits to 1 (blocked). The general request needs the global enable and has no mask.
- R5: The global enable is 0 after reset. `ena_set_i` sets it and `ena_clr_i` clears it, and clear wins if both are asserted. Any acceptance clears it, and this overrides a set in the same cycle.
- R6: Accepting the general request pulses `ack_o` and `pc_hold_o` together for one cycle. In that cycle `vec_valid_o` stays low.
- R7: The trap needs a rising edge followed by a level that is still high at the sample cycle. A trap that falls before sampling is dropped. A trap held high after its acceptance is not taken again until it falls and rises once more.
- R8: A rising edge on the high restart line sets a pending flag (`hi_pend_o`). The flag persists after the line falls, until that source is accepted or `hi_pend_clr_i` is pulsed. A new edge in the same cycle as a clear keeps the flag set.
- R9: The middle and low restart lines are level sensitive. A level that is gone by the sample cycle leaves no trace.
- R10: The vector is 0x0024 for the trap, 0x003C for high, 0x0034 for middle and 0x002C for low. `vec_valid_o` marks it.
- R11: Priority ignores which source was accepted last. Once the enable is set again, a weaker source is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable trap request |
| rq_hi_i | input | 1 | High restart request, edge latched |
| rq_mid_i | input | 1 | Middle restart request, level |
| rq_lo_i | input | 1 | Low restart request, level |
| gen_req_i | input | 1 | General request needing external instruction |
| sample_i | input | 1 | Next-to-last clock of the current instruction |
| ena_set_i | input | 1 | Set the global enable |
| ena_clr_i | input | 1 | Clear the global enable |
| mask_we_i | input | 1 | Load the mask bits |
| mask_wdata_i | input | 3 | New mask bits (2 high, 1 middle, 0 low; 1 blocks) |
| hi_pend_clr_i | input | 1 | Clear the high-line pending flag |
| take_o | output | 1 | A source was accepted |
| src_o | output | 5 | One-hot accepted source |
| vec_valid_o | output | 1 | `vec_o` holds a restart vector |
| vec_o | output | ADDR_W | Restart vector address |
| ack_o | output | 1 | Acknowledge strobe for the general request |
| pc_hold_o | output | 1 | Inhibit program-counter increment |
| ie_o | output | 1 | Global enable state |
| mask_o | output | 3 | Mask bit state |
| hi_pend_o | output | 1 | High-line pending flag |

## Verification
Two events can land on the same edge: an acceptance, which clears the global enable, and a software write to that enable. A second such pair is a pending clear on the high line together with a fresh edge on it. The bench raises `ena_set_i` in the sample cycle of an accepted request, and it requires `ie_o` to read 0 afterwards. It also pulses `hi_pend_clr_i` on the cycle where the high line rises, and it requires `hi_pend_o` to remain set. Beyond that, a sweep covers all 32 request patterns under every mask value and both enable states. The bench computes the winner, the vector and the enable from the priority rules.

// File: rtl/restart_intc_pkg.sv
package restart_intc_pkg;
  localparam int NSRC     = 5;
  localparam int NRST     = 3;
  localparam int IDX_GEN  = 0;
  localparam int IDX_LO   = 1;
  localparam int IDX_MID  = 2;
  localparam int IDX_HI   = 3;
  localparam int IDX_TRAP = 4;

  // Restart address: level times eight plus four.
  function automatic logic [15:0] restart_vec(input logic [2:0] lvl);
    return {10'd0, lvl, 3'b100};
  endfunction

  // Map a one-hot grant onto its restart address; zero for none or general.
  function automatic logic [15:0] grant_vec(input logic [NSRC-1:0] g);
    if (g[IDX_TRAP])     return restart_vec(3'd4);
    else if (g[IDX_HI])  return restart_vec(3'd7);
    else if (g[IDX_MID]) return restart_vec(3'd6);
    else if (g[IDX_LO])  return restart_vec(3'd5);
    else                 return 16'd0;
  endfunction
endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr_i,
  output logic q_o
);
  logic prev_q;
  logic held_q;
  logic rise_w;

  assign rise_w = din & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= din;
      if (rise_w)                 held_q <= 1'b1;
      else if (clr_i)             held_q <= 1'b0;
      else if (!STICKY && !din)   held_q <= 1'b0;
    end
  end

  assign q_o = held_q;

  generate
    if (STICKY) begin : g_sticky
      // R8: pending flag stays until serviced or cleared
      a_r8_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !clr_i) |=> held_q);
    end else begin : g_level
      // R7: an armed trap implies the line was high on the previous cycle
      a_r7_armed_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        held_q |-> $past(din));
    end
  endgenerate
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs #(
  parameter int NMSK = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic            take_i,
  input  logic            mask_we_i,
  input  logic [NMSK-1:0] mask_wdata_i,
  output logic            ie_o,
  output logic [NMSK-1:0] mask_o
);
  logic            ie_q;
  logic [NMSK-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (take_i)     ie_q <= 1'b0;
      else if (clr_i) ie_q <= 1'b0;
      else if (set_i) ie_q <= 1'b1;
      if (mask_we_i)  mask_q <= mask_wdata_i;
    end
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;

  // R5: acceptance always leaves the enable cleared
  a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !ie_q);
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) grant_o = N'(1) << i;
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/restart_intc.sv
module restart_intc
  import restart_intc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              rq_hi_i,
  input  logic              rq_mid_i,
  input  logic              rq_lo_i,
  input  logic              gen_req_i,
  input  logic              sample_i,
  input  logic              ena_set_i,
  input  logic              ena_clr_i,
  input  logic              mask_we_i,
  input  logic [NRST-1:0]   mask_wdata_i,
  input  logic              hi_pend_clr_i,
  output logic              take_o,
  output logic [NSRC-1:0]   src_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              ack_o,
  output logic              pc_hold_o,
  output logic              ie_o,
  output logic [NRST-1:0]   mask_o,
  output logic              hi_pend_o
);
  logic            trap_armed_w;
  logic            hi_pend_w;
  logic            ie_w;
  logic [NRST-1:0] mask_w;
  logic [NSRC-1:0] elig_w;
  logic [NSRC-1:0] req_w;
  logic [NSRC-1:0] grant_w;
  logic            accept_w;

  intc_edge_latch #(.STICKY(1'b0)) u_trap_edge (
    .clk(clk), .rst_n(rst_n), .din(trap_i),
    .clr_i(grant_w[IDX_TRAP]), .q_o(trap_armed_w));

  intc_edge_latch #(.STICKY(1'b1)) u_hi_edge (
    .clk(clk), .rst_n(rst_n), .din(rq_hi_i),
    .clr_i(grant_w[IDX_HI] | hi_pend_clr_i), .q_o(hi_pend_w));

  intc_ctrl_regs #(.NMSK(NRST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .set_i(ena_set_i), .clr_i(ena_clr_i),
    .take_i(accept_w), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .ie_o(ie_w), .mask_o(mask_w));

  assign elig_w[IDX_TRAP] = trap_armed_w & trap_i;
  assign elig_w[IDX_HI]   = hi_pend_w & ie_w & ~mask_w[2];
  assign elig_w[IDX_MID]  = rq_mid_i  & ie_w & ~mask_w[1];
  assign elig_w[IDX_LO]   = rq_lo_i   & ie_w & ~mask_w[0];
  assign elig_w[IDX_GEN]  = gen_req_i & ie_w;

  assign req_w = sample_i ? elig_w : '0;

  intc_prio_pick #(.N(NSRC)) u_pick (
    .req_i(req_w), .grant_o(grant_w), .any_o(accept_w));

  logic              take_q;
  logic [NSRC-1:0]   src_q;
  logic              vvld_q;
  logic [ADDR_W-1:0] vec_q;
  logic              ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= '0;
      vvld_q <= 1'b0;
      vec_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      take_q <= accept_w;
      src_q  <= grant_w;
      vvld_q <= accept_w & ~grant_w[IDX_GEN];
      vec_q  <= ADDR_W'(grant_vec(grant_w));
      ack_q  <= grant_w[IDX_GEN];
    end
  end

  assign take_o      = take_q;
  assign src_o       = src_q;
  assign vec_valid_o = vvld_q;
  assign vec_o       = vec_q;
  assign ack_o       = ack_q;
  assign pc_hold_o   = ack_q;
  assign ie_o        = ie_w;
  assign mask_o      = mask_w;
  assign hi_pend_o   = hi_pend_w;

  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_o) && (take_o == (|src_o)));
  a_r2_take_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));
  a_r3_trap_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    src_o[IDX_TRAP] |-> $past(trap_i));
  a_r4_maskable_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_o[IDX_HI:IDX_GEN]) |-> $past(ie_o));
  a_r5_ie_low_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_o);
  a_r6_ack_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (pc_hold_o && !vec_valid_o && take_o));
endmodule

// File: tb/restart_intc_tb.sv
module restart_intc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_i = 0, rq_hi_i = 0, rq_mid_i = 0, rq_lo_i = 0, gen_req_i = 0;
  logic sample_i = 0, ena_set_i = 0, ena_clr_i = 0, mask_we_i = 0, hi_pend_clr_i = 0;
  logic [2:0] mask_wdata_i = 3'b000;
  logic        take_o, vec_valid_o, ack_o, pc_hold_o, ie_o, hi_pend_o;
  logic [4:0]  src_o;
  logic [15:0] vec_o;
  logic [2:0]  mask_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  restart_intc #(.ADDR_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rq_hi_i(rq_hi_i),
    .rq_mid_i(rq_mid_i), .rq_lo_i(rq_lo_i), .gen_req_i(gen_req_i),
    .sample_i(sample_i), .ena_set_i(ena_set_i), .ena_clr_i(ena_clr_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .hi_pend_clr_i(hi_pend_clr_i),
    .take_o(take_o), .src_o(src_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o),
    .ack_o(ack_o), .pc_hold_o(pc_hold_o), .ie_o(ie_o), .mask_o(mask_o),
    .hi_pend_o(hi_pend_o));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // All requests low, pending cleared, mask written, enable chosen.
  task automatic prep(input logic [2:0] m, input bit en);
    {trap_i, rq_hi_i, rq_mid_i, rq_lo_i, gen_req_i} = '0;
    hi_pend_clr_i = 1; mask_we_i = 1; mask_wdata_i = m;
    ena_set_i = en; ena_clr_i = !en;
    tick;
    hi_pend_clr_i = 0; mask_we_i = 0; ena_set_i = 0; ena_clr_i = 0;
  endtask

  task automatic sample_once;
    sample_i = 1;
    tick;
    sample_i = 0;
  endtask

  function automatic logic [24:0] pack_out();
    return {take_o, src_o, vec_valid_o, vec_o, ack_o, pc_hold_o};
  endfunction

  function automatic int winner(input logic [4:0] r, input logic [2:0] m, input bit en);
    if (r[4]) return 4;
    if (!en) return -1;
    if (r[3] && !m[2]) return 3;
    if (r[2] && !m[1]) return 2;
    if (r[1] && !m[0]) return 1;
    if (r[0]) return 0;
    return -1;
  endfunction

  function automatic logic [24:0] expect_out(input int w);
    logic [15:0] v;
    case (w)
      4: v = 16'h0024;
      3: v = 16'h003C;
      2: v = 16'h0034;
      1: v = 16'h002C;
      default: v = 16'h0000;
    endcase
    if (w < 0) return '0;
    return {1'b1, 5'(1 << w), (w != 0), v, (w == 0), (w == 0)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state: R5 enable off, R4 masks all blocking, R2 nothing taken
    chk(ie_o == 0, "R5 reset enable", ie_o, 0);
    chk(mask_o == 3'b111, "R4 reset mask", mask_o, 3'b111);
    chk(pack_out() == 0, "R2 reset outputs", pack_out(), 0);

    // Sweep all requests x masks x enable
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int r = 0; r < 32; r++) begin
          int w;
          string tg;
          prep(3'(m), e[0]);
          {trap_i, rq_hi_i, rq_mid_i, rq_lo_i, gen_req_i} = 5'(r);
          tick;
          sample_once;
          w = winner(5'(r), 3'(m), e[0]);
          tg = (w == 4) ? "R3 R1" : (w == 0) ? "R6 R1" : (w > 0) ? "R10 R1" : "R4";
          chk(pack_out() == expect_out(w), tg, pack_out(), expect_out(w));
          chk(ie_o == (e[0] && w < 0), "R5 enable after sample", ie_o, (e[0] && w < 0));
          tick;
          chk(take_o == 0, "R2 single cycle result", take_o, 0);
        end
      end
    end

    // R2: no sample, no take
    prep(3'b000, 1);
    {rq_mid_i, gen_req_i} = 2'b11;
    for (int k = 0; k < 3; k++) begin
      tick;
      chk(take_o == 0, "R2 no sample", take_o, 0);
    end
    sample_once;
    chk(src_o == 5'b00100, "R2 sample takes", src_o, 5'b00100);

    // R7: held trap not retaken; dropped trap ignored; new edge taken
    prep(3'b111, 0);
    trap_i = 1; tick; sample_once;
    chk(src_o == 5'b10000, "R7 trap edge taken", src_o, 5'b10000);
    tick; sample_once;
    chk(take_o == 0, "R7 held trap not retaken", take_o, 0);
    trap_i = 0; tick; trap_i = 1; tick; trap_i = 0; sample_once;
    chk(take_o == 0, "R7 fallen trap dropped", take_o, 0);
    trap_i = 1; tick; sample_once;
    chk(src_o == 5'b10000, "R7 fresh edge taken", src_o, 5'b10000);

    // R8: pending persists, clear removes, edge beats clear
    prep(3'b000, 0);
    rq_hi_i = 1; tick; rq_hi_i = 0; tick;
    chk(hi_pend_o == 1, "R8 pending after drop", hi_pend_o, 1);
    ena_set_i = 1; tick; ena_set_i = 0;
    sample_once;
    chk(vec_o == 16'h003C && take_o, "R8 pending serviced", vec_o, 16'h003C);
    chk(hi_pend_o == 0, "R8 cleared by service", hi_pend_o, 0);
    rq_hi_i = 1; tick; rq_hi_i = 0;
    hi_pend_clr_i = 1; tick; hi_pend_clr_i = 0;
    chk(hi_pend_o == 0, "R8 software clear", hi_pend_o, 0);
    ena_set_i = 1; tick; ena_set_i = 0; sample_once;
    chk(take_o == 0, "R8 cleared not taken", take_o, 0);
    rq_hi_i = 1; hi_pend_clr_i = 1; tick; hi_pend_clr_i = 0; rq_hi_i = 0;
    chk(hi_pend_o == 1, "R8 edge beats clear", hi_pend_o, 1);

    // R9: level lines leave no trace
    prep(3'b000, 1);
    rq_mid_i = 1; rq_lo_i = 1; tick; rq_mid_i = 0; rq_lo_i = 0; tick;
    sample_once;
    chk(take_o == 0, "R9 level gone", take_o, 0);

    // R5: set and accept in same cycle; clear wins over set
    prep(3'b000, 1);
    gen_req_i = 1; tick;
    ena_set_i = 1; sample_once; ena_set_i = 0;
    chk(ie_o == 0 && ack_o, "R5 accept beats set", ie_o, 0);
    gen_req_i = 0;
    ena_set_i = 1; ena_clr_i = 1; tick; ena_set_i = 0; ena_clr_i = 0;
    chk(ie_o == 0, "R5 clear beats set", ie_o, 0);

    // R11: weaker source taken after re-enable following a stronger one
    prep(3'b000, 1);
    rq_hi_i = 1; tick; sample_once; rq_hi_i = 0;
    chk(src_o == 5'b01000, "R11 high first", src_o, 5'b01000);
    rq_lo_i = 1; ena_set_i = 1; tick; ena_set_i = 0; sample_once;
    chk(src_o == 5'b00010 && vec_o == 16'h002C, "R11 low after re-enable", src_o, 5'b00010);
    rq_lo_i = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule